// File: doc/BRIEF.md
# Shared-Word Interrupt Aggregator

This block collects single-cycle event pulses from a small, parameterized group of interrupt sources and presents them to software through one 32-bit register. Each source is tracked by two bits in that register. The low half of the word holds the mask bits, which are plain read/write storage. The high half holds the sticky pending flags, which are cleared by writing one. A source's pending flag always sits exactly 16 positions above its mask bit.

The group of sources occupies a contiguous window that may start above bit zero. For example, two sources can live at mask bits 4 and 5, with their flags at bits 20 and 21. Bits outside the window do not exist: they read as zero and ignore writes.

A single registered, level-style line tells the parent controller that at least one unmasked source has a pending flag. Software reads the word, services one pending source, and writes a one to that source's flag. The line drops once nothing unmasked remains pending.

The register port is a single-cycle strobe interface. A write-enable or read-enable acts only when the word address matches a parameterized offset. Read data is combinational.

Top module: `irq_word_agg`

## Requirements
- R1: Read data places mask bit k at bit k and pending flag k at bit k+16 of the 32-bit word, where k = SRC_LSB + source index.
- R2: A selected write replaces every in-window mask bit with the matching bit of write data bits [15:0]; mask bits change at no other time.
- R3: A selected write clears each in-window pending flag whose bit in write data bits [31:16] is 1. A 0 in that field leaves the flag as it was.
- R4: A 0-to-1 transition of a source input sets its pending flag on the next clock edge, whether the source is masked or not. A source held high sets its flag only once.
- R5: When a source transition and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R6: Mask and flag bits outside the window always read as zero, and writes to them have no effect.
- R7: irq_o is 1 exactly when, at the previous clock edge, some source had both its mask bit and its pending flag set. It therefore lags any change of flag or mask by one clock.
- R8: A write has effect only when wr_en_i is 1 and addr_i equals REG_ADDR. rdata_o is zero unless rd_en_i is 1 and addr_i equals REG_ADDR.
- R9: While rst_n is low, all mask and flag bits are zero and irq_o is 0.
- R10: Clearing a mask bit keeps that source's pending flag. Setting the mask bit again re-raises irq_o one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Source event inputs; rising edges are captured |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Word address, compared against REG_ADDR |
| wdata_i | input | 32 | Write data: [15:0] mask, [31:16] write-one-to-clear flags |
| rdata_o | output | 32 | Read data, same cycle as the read strobe |
| irq_o | output | 1 | Registered summary interrupt to the parent |

## Verification
The two functions that can collide are event capture and the write-one clear. A source rising edge and a write that clears the same flag can fall into one clock. The bench drives both in the same cycle and expects the flag to read back as set. It also drives a clear while the source input is still held high and expects the flag to stay clear, since only an edge may set it. A behavioural per-bit model, updated on every clock, judges read data and the summary line after every cycle, including the one-clock lag of the line after each of these events.

// File: rtl/irq_word_pkg.sv
package irq_word_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    typedef struct packed {
        logic [HALF_W-1:0] mask;
        logic [HALF_W-1:0] flag;
        logic              irq;
    } agg_state_t;

    // One bit set for every position inside the source window.
    function automatic logic [HALF_W-1:0] window_bits(int count, int lsb);
        logic [HALF_W-1:0] m;
        m = '0;
        for (int b = 0; b < HALF_W; b++) begin
            if (b >= lsb && b < lsb + count) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_src_edge.sv
module irq_src_edge #(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_SRC-1:0] rise_o
);

    logic [NUM_SRC-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_rise
        assign rise_o[g] = src_i[g] & ~prev_q[g];
    end

endmodule

// File: rtl/irq_word_state.sv
module irq_word_state
    import irq_word_pkg::*;
#(
    parameter int NUM_SRC = 7,
    parameter int SRC_LSB = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic [HALF_W-1:0] rise_pos,
    output logic [HALF_W-1:0] mask_o,
    output logic [HALF_W-1:0] flag_o,
    output logic              irq_o
);

    localparam logic [HALF_W-1:0] WIN = window_bits(NUM_SRC, SRC_LSB);

    agg_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // summary follows the registered word, one clock behind it
        st_d.irq = |(st_q.mask & st_q.flag);
        if (wr_sel) begin
            st_d.mask = wdata[HALF_W-1:0] & WIN;
            st_d.flag = st_q.flag & ~(wdata[WORD_W-1:HALF_W] & WIN);
        end
        // capture is applied after the clear so a same-cycle event survives
        st_d.flag = st_d.flag | (rise_pos & WIN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign flag_o = st_q.flag;
    assign irq_o  = st_q.irq;

endmodule

// File: rtl/irq_word_agg.sv
module irq_word_agg
    import irq_word_pkg::*;
#(
    parameter int NUM_SRC  = 7,
    parameter int SRC_LSB  = 0,
    parameter int ADDR_W   = 4,
    parameter int REG_ADDR = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    output logic               irq_o
);

    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(REG_ADDR);
    localparam logic [HALF_W-1:0] WIN      = window_bits(NUM_SRC, SRC_LSB);

    logic              wr_sel, rd_sel;
    logic [NUM_SRC-1:0] rise;
    logic [HALF_W-1:0] rise_pos;
    logic [HALF_W-1:0] mask_q, flag_q;
    logic [HALF_W-1:0] win_bits;

    assign wr_sel   = wr_en_i && (addr_i == SEL_ADDR);
    assign rd_sel   = rd_en_i && (addr_i == SEL_ADDR);
    assign rise_pos = HALF_W'(rise) << SRC_LSB;
    assign win_bits = WIN;

    irq_src_edge #(
        .NUM_SRC (NUM_SRC)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .rise_o (rise)
    );

    irq_word_state #(
        .NUM_SRC (NUM_SRC),
        .SRC_LSB (SRC_LSB)
    ) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (wr_sel),
        .wdata    (wdata_i),
        .rise_pos (rise_pos),
        .mask_o   (mask_q),
        .flag_o   (flag_q),
        .irq_o    (irq_o)
    );

    assign rdata_o = rd_sel ? {flag_q, mask_q} : '0;

endmodule

// File: rtl/irq_word_chk.sv
module irq_word_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_sel,
    input logic [31:0] wdata,
    input logic [15:0] rise_pos,
    input logic [15:0] win_bits,
    input logic [15:0] mask_q,
    input logic [15:0] flag_q,
    input logic        irq_o
);

    // R7: summary line reflects the word one clock earlier
    a_r7_irq_lags: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(mask_q & flag_q)));

    // R2: mask bits only move on a selected write
    a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(mask_q));

    // R3: a write with zeros in the flag field removes no flag
    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && wdata[31:16] == 16'h0) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R5: a captured event is always visible on the next edge, clear or not
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_pos & win_bits) != 16'h0) |=>
            ((flag_q & $past(rise_pos & win_bits)) == $past(rise_pos & win_bits)));

    // R4: a flag can only appear where an event was seen
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(rise_pos)) == 16'h0));

    // R6: nothing is ever stored outside the window
    a_r6_window: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_q | flag_q) & ~win_bits) == 16'h0);

endmodule

bind irq_word_agg irq_word_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_sel   (wr_sel),
    .wdata    (wdata_i),
    .rise_pos (rise_pos),
    .win_bits (win_bits),
    .mask_q   (mask_q),
    .flag_q   (flag_q),
    .irq_o    (irq_o)
);

// File: tb/sim_irq_word_agg.sv
`timescale 1ns/1ps
module sim_irq_word_agg;

    localparam int NS   = 2;
    localparam int LSB  = 4;
    localparam int AW   = 4;
    localparam int RADR = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b1;
    logic [AW-1:0] addr = AW'(RADR);
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit run   = 1'b0;

    always #10 clk = ~clk;

    irq_word_agg #(
        .NUM_SRC (NS),
        .SRC_LSB (LSB),
        .ADDR_W  (AW),
        .REG_ADDR(RADR)
    ) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    // behavioural reference: one integer-indexed loop over bit positions
    logic [15:0]   m_mask, m_flag;
    logic [NS-1:0] m_prev;
    logic          m_irq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mask = '0; m_flag = '0; m_prev = '0; m_irq = 1'b0;
        end else begin
            m_irq = 1'b0;
            for (int b = 0; b < 16; b++) if (m_mask[b] && m_flag[b]) m_irq = 1'b1;
            if (wr_en && addr == AW'(RADR)) begin
                for (int b = 0; b < 16; b++) begin
                    if (b >= LSB && b < LSB + NS) begin
                        m_mask[b] = wdata[b];
                        if (wdata[b+16]) m_flag[b] = 1'b0;
                    end
                end
            end
            for (int i = 0; i < NS; i++) begin
                if (src[i] && !m_prev[i]) m_flag[LSB+i] = 1'b1;
                m_prev[i] = src[i];
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        #5;
        if (run) begin
            chk("R1 rdata vs model", rdata,
                (rd_en && addr == AW'(RADR)) ? {m_flag, m_mask} : 32'h0);
            chk("R7 irq vs model", {31'h0, irq}, {31'h0, m_irq});
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(logic [31:0] v);
        step(); wr_en = 1'b1; wdata = v;
        step(); wr_en = 1'b0; wdata = '0;
        #6;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        run   = 1'b1;
        #6;
        chk("R9 reset word", rdata, 32'h0);
        chk("R9 reset irq", {31'h0, irq}, 32'h0);

        // R2 R6: all-ones write keeps only window mask bits
        wr(32'hFFFF_FFFF);
        chk("R2 R6 mask window", rdata, 32'h0000_0030);

        // R4 R7: pulse source 0, flag at bit 20, line one clock later
        step(); src = 2'b01;
        step(); src = 2'b00; #6;
        chk("R4 flag set", rdata, 32'h0010_0030);
        chk("R7 lag cycle", {31'h0, irq}, 32'h0);
        step(); #6;
        chk("R7 raised", {31'h0, irq}, 32'h1);

        // R10 R3: mask everything, flag kept
        wr(32'h0000_0000);
        chk("R10 flag kept", rdata, 32'h0010_0000);
        step(); #6;
        chk("R7 drop after mask", {31'h0, irq}, 32'h0);
        wr(32'h0000_0010);
        step(); #6;
        chk("R10 unmask reraises", {31'h0, irq}, 32'h1);

        // R3: write-one clear
        wr(32'h0010_0030);
        chk("R3 w1c", rdata, 32'h0000_0030);
        step(); #6;
        chk("R3 irq dropped", {31'h0, irq}, 32'h0);

        // R4: held-high source sets once, clear sticks
        step(); src = 2'b10;
        step(); step(); #6;
        chk("R4 held set", rdata, 32'h0020_0030);
        wr(32'h0020_0030);
        chk("R4 no reset while held", rdata, 32'h0000_0030);
        step(); src = 2'b00;

        // R5: event and clear of the same flag in one cycle
        step(); src = 2'b01; wr_en = 1'b1; wdata = 32'h0010_0030;
        step(); src = 2'b00; wr_en = 1'b0; wdata = '0; #6;
        chk("R5 set wins", rdata, 32'h0010_0030);
        wr(32'h0010_0030);

        // R8: address and strobe decode
        step(); addr = AW'(RADR + 1); wr_en = 1'b1; wdata = 32'h0000_0000;
        step(); wr_en = 1'b0; #6;
        chk("R8 read other addr", rdata, 32'h0);
        addr = AW'(RADR); #1;
        chk("R8 write other addr ignored", rdata, 32'h0000_0030);
        rd_en = 1'b0; #1;
        chk("R8 no read strobe", rdata, 32'h0);
        rd_en = 1'b1;

        // R4 R7: masked source still latches, line stays low
        wr(32'h0000_0010);
        step(); src = 2'b10;
        step(); src = 2'b00; #6;
        chk("R4 masked latches", rdata, 32'h0020_0010);
        step(); step(); #6;
        chk("R7 masked no irq", {31'h0, irq}, 32'h0);

        // R6: out-of-window ones, in-window zeros
        wr(32'hFFCF_FFCF);
        chk("R6 outside ignored", rdata, 32'h0020_0000);

        // R1: layout with mask bit 5 and flag bit 21
        wr(32'h0000_0020);
        chk("R1 layout", rdata, 32'h0020_0020);
        step(); #6;
        chk("R1 irq from pair", {31'h0, irq}, 32'h1);

        // R9: reset mid-run
        step(); rst_n = 1'b0; #6;
        chk("R9 mid reset word", rdata, 32'h0);
        chk("R9 mid reset irq", {31'h0, irq}, 32'h0);
        step(); rst_n = 1'b1;
        repeat (3) step();
        #8;
        finish_run();
    end

endmodule